// File: doc/BRIEF.md
# USB Suspend and Resume Detector

This block watches the decoded state of the USB data lines and produces two single-cycle event pulses for the interrupt status logic. The sleep pulse tells the device that the bus has been idle for long enough that it should suspend. The resume pulse tells the device that the host, or a remote-wakeup source, has driven a K-state on the lines for long enough to count as resume signalling.

Both thresholds are counted in cycles of a fixed-frequency timing clock. At 12 MHz the defaults are 36000 cycles (3 ms) for idle and 30 cycles (2.5 µs) for K. The sleep timer restarts whenever the line leaves the idle state.

The resume detector only listens once the module is heading into suspend. It is armed by the sleep event. It only counts K-state time while the `clk_run` input reports that the module's clocks have restarted. The arm is withdrawn when a resume is reported or when a USB reset (SE0) appears.

Top module: `usb_susp_resume_det`

## Requirements
- R1: After reset both pulses are low and the resume detector is disarmed.
- R2: `sleep_pulse` is high for exactly one cycle. It goes high on the clock edge that follows the IDLE_CYCLES-th consecutive cycle in which the line is idle (`line_state` = 2'b00, J).
- R3: Any cycle in which the line is not idle (K = 2'b01, SE0 = 2'b10 or 2'b11) restarts the idle count from zero.
- R4: Within one unbroken idle interval, `sleep_pulse` fires at most once. It can fire again only after the line has left the idle state.
- R5: The detector becomes armed on the edge after `sleep_pulse`. While it is disarmed, no K-state activity produces `resume_pulse`.
- R6: While armed and with `clk_run` high, `resume_pulse` is high for exactly one cycle. It goes high on the clock edge that follows the KSTATE_CYCLES-th consecutive cycle in which the line is K (`line_state` = 2'b01).
- R7: A cycle with `clk_run` low, or with the line not in K, restarts the K-state count from zero.
- R8: `resume_pulse` disarms the detector. Further K-state time gives no further resume until a new `sleep_pulse` rearms it.
- R9: An SE0 cycle (`line_state` = 2'b10) disarms the detector. A clear takes precedence over a set in the same cycle.
- R10: Line code 2'b11 counts as bus activity. It restarts the idle count and is not counted as K.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fixed-frequency timing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_state | input | 2 | Decoded line state: 00 J/idle, 01 K, 10 SE0, 11 invalid |
| clk_run | input | 1 | High once the module's clocks have restarted |
| sleep_pulse | output | 1 | One-cycle idle-timeout event |
| resume_pulse | output | 1 | One-cycle resume-detected event |

## Verification
The hardest state to reach from the ports is an armed detector that is then disarmed by something other than a resume. Reaching it means sitting through a complete idle timeout first, and only then applying SE0 or a K burst. The stimulus therefore chains phases in order: a full idle timeout to arm, then SE0, then a long K burst that must stay silent, then a second timeout to rearm. It then interrupts a K burst by dropping `clk_run`, checking that the count restarts rather than resumes. The bench shortens both thresholds through the parameters so that several full arm/disarm cycles fit in one run.

// File: rtl/usb_srd_pkg.sv
package usb_srd_pkg;

  typedef enum logic [1:0] {
    LS_J   = 2'b00,
    LS_K   = 2'b01,
    LS_SE0 = 2'b10,
    LS_BAD = 2'b11
  } line_t;

  function automatic logic ls_is_idle(input logic [1:0] ls);
    return ls == LS_J;
  endfunction

  function automatic logic ls_is_k(input logic [1:0] ls);
    return ls == LS_K;
  endfunction

  function automatic logic ls_is_se0(input logic [1:0] ls);
    return ls == LS_SE0;
  endfunction

  // counter width able to hold values 0 .. limit
  function automatic int cnt_w(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/usb_srd_run_timer.sv
// Counts consecutive cycles with run high; emits one registered pulse when
// the count reaches LIMIT, then stays quiet until run drops.
module usb_srd_run_timer #(
  parameter int unsigned LIMIT = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic hit
);
  localparam int W = usb_srd_pkg::cnt_w(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;
  logic         fired;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      fired <= 1'b0;
      hit   <= 1'b0;
    end else if (!run) begin
      cnt   <= '0;
      fired <= 1'b0;
      hit   <= 1'b0;
    end else if (fired) begin
      hit   <= 1'b0;
    end else if (cnt == LAST) begin
      hit   <= 1'b1;
      fired <= 1'b1;
    end else begin
      cnt   <= cnt + 1'b1;
      hit   <= 1'b0;
    end
  end
endmodule

// File: rtl/usb_srd_arm.sv
// Resume-detector arm flag; clear wins over set.
module usb_srd_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic armed_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      armed_o <= 1'b0;
    else if (clr_i)  armed_o <= 1'b0;
    else if (set_i)  armed_o <= 1'b1;
  end
endmodule

// File: rtl/usb_susp_resume_det.sv
module usb_susp_resume_det #(
  parameter int unsigned IDLE_CYCLES   = 36000,
  parameter int unsigned KSTATE_CYCLES = 30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] line_state,
  input  logic       clk_run,
  output logic       sleep_pulse,
  output logic       resume_pulse
);
  import usb_srd_pkg::*;

  // named internal events, observed by the bound checker
  logic idle_now;
  logic kstate_now;
  logic se0_now;
  logic armed;
  logic resume_run;

  assign idle_now   = ls_is_idle(line_state);
  assign kstate_now = ls_is_k(line_state);
  assign se0_now    = ls_is_se0(line_state);
  assign resume_run = armed && clk_run && kstate_now;

  usb_srd_run_timer #(.LIMIT(IDLE_CYCLES)) u_idle_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (idle_now),
    .hit   (sleep_pulse)
  );

  usb_srd_run_timer #(.LIMIT(KSTATE_CYCLES)) u_k_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (resume_run),
    .hit   (resume_pulse)
  );

  usb_srd_arm u_arm (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (sleep_pulse),
    .clr_i   (resume_pulse || se0_now),
    .armed_o (armed)
  );
endmodule

// File: rtl/usb_srd_checker.sv
module usb_srd_checker (
  input logic clk,
  input logic rst_n,
  input logic idle_now,
  input logic kstate_now,
  input logic se0_now,
  input logic armed,
  input logic clk_run,
  input logic sleep_pulse,
  input logic resume_pulse
);
  assert_sleep_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_pulse |=> !sleep_pulse);

  assert_sleep_after_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_pulse) |-> $past(idle_now));

  assert_sleep_arms_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_pulse && !se0_now && !resume_pulse) |=> armed);

  assert_resume_needs_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resume_pulse) |-> $past(armed));

  assert_resume_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    resume_pulse |=> !resume_pulse);

  assert_resume_after_k_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resume_pulse) |-> $past(kstate_now && clk_run));

  assert_resume_disarms_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resume_pulse |=> !armed);

  assert_se0_disarms_R9: assert property (@(posedge clk) disable iff (!rst_n)
    se0_now |=> !armed);
endmodule

bind usb_susp_resume_det usb_srd_checker u_srd_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .idle_now     (idle_now),
  .kstate_now   (kstate_now),
  .se0_now      (se0_now),
  .armed        (armed),
  .clk_run      (clk_run),
  .sleep_pulse  (sleep_pulse),
  .resume_pulse (resume_pulse)
);

// File: tb/usb_susp_resume_det_bench.sv
`timescale 1ns/1ps
module usb_susp_resume_det_bench;
  localparam int unsigned IDLE_N = 40;
  localparam int unsigned K_N    = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] line_state = 2'b00;
  logic       clk_run = 1'b1;
  logic       sleep_pulse, resume_pulse;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  usb_susp_resume_det #(.IDLE_CYCLES(IDLE_N), .KSTATE_CYCLES(K_N)) u_usb_susp_resume_det (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_state   (line_state),
    .clk_run      (clk_run),
    .sleep_pulse  (sleep_pulse),
    .resume_pulse (resume_pulse)
  );

  // scoreboard queues
  logic  q_s[$];
  logic  q_r[$];
  string q_tag[$];

  // requirement-level reference state
  int m_idle_run = 0;
  int m_k_run    = 0;
  bit m_arm      = 0;
  bit m_sleep    = 0;
  bit m_res      = 0;
  int n_sleep    = 0;
  int n_res      = 0;

  task automatic drive(input logic [1:0] ls, input logic run, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      bit nxt_sleep, nxt_res, nxt_arm, krun;
      @(negedge clk);
      line_state = ls;
      clk_run    = run;
      // idle: count consecutive J samples; pulse exactly at the IDLE_N-th
      if (ls == 2'b00) m_idle_run++; else m_idle_run = 0;
      nxt_sleep = (m_idle_run == IDLE_N);
      // K while armed and clocks running
      krun = m_arm && run && (ls == 2'b01);
      if (krun) m_k_run++; else m_k_run = 0;
      nxt_res = (m_k_run == K_N);
      // arm: clear on SE0 or reported resume, set after sleep
      if (ls == 2'b10 || m_res) nxt_arm = 0;
      else if (m_sleep)         nxt_arm = 1;
      else                      nxt_arm = m_arm;
      m_sleep = nxt_sleep;
      m_res   = nxt_res;
      m_arm   = nxt_arm;
      q_s.push_back(nxt_sleep);
      q_r.push_back(nxt_res);
      q_tag.push_back(tag);
    end
  endtask

  // monitor: compare after every active edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_s.size() > 0) begin
        logic es, er;
        string t;
        es = q_s.pop_front();
        er = q_r.pop_front();
        t  = q_tag.pop_front();
        tests++;
        if (sleep_pulse !== es || resume_pulse !== er) begin
          fails++;
          $display("FAIL %s: sleep/resume actual %b/%b expected %b/%b at %0t",
                   t, sleep_pulse, resume_pulse, es, er, $time);
        end
        if (sleep_pulse === 1'b1) n_sleep++;
        if (resume_pulse === 1'b1) n_res++;
      end
    end
  end

  task automatic check_count(input int act, input int exp, input string tag);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: pulse count actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    tests++;  // R1 reset state
    if (sleep_pulse !== 1'b0 || resume_pulse !== 1'b0) begin
      fails++;
      $display("FAIL R1: pulses actual %b/%b expected 0/0", sleep_pulse, resume_pulse);
    end

    // R3 / R10: interrupted idle never times out
    drive(2'b00, 1, 30, "R3 idle partial");
    drive(2'b01, 1, 3,  "R3 K breaks idle");
    drive(2'b00, 1, 30, "R3 idle partial");
    drive(2'b10, 1, 2,  "R3 SE0 breaks idle");
    drive(2'b00, 1, 39, "R3 idle one short");
    drive(2'b11, 1, 1,  "R10 code 11 is activity");
    drive(2'b00, 1, 39, "R10 idle one short");
    drive(2'b01, 1, 8,  "R5 K while disarmed");
    check_count(n_sleep, 0, "R3 no early sleep");
    check_count(n_res, 0, "R5 no resume disarmed");

    // R2 / R4: timeout then silence
    drive(2'b00, 1, 45, "R2 idle timeout");
    drive(2'b00, 1, 60, "R4 no repeat in same idle");
    check_count(n_sleep, 1, "R4 single sleep");

    // R9: SE0 disarms, then long K is silent
    drive(2'b10, 1, 1,  "R9 SE0 disarm");
    drive(2'b01, 1, 12, "R9 K after disarm");
    check_count(n_res, 0, "R9 no resume after SE0");

    // rearm; R7: clk_run low restarts K count
    drive(2'b00, 1, 45, "R5 rearm via sleep");
    drive(2'b01, 1, 3,  "R7 K part");
    drive(2'b01, 0, 2,  "R7 clocks stopped");
    drive(2'b01, 1, 4,  "R7 K restarted short");
    check_count(n_res, 0, "R7 count restarted");
    drive(2'b01, 1, 3,  "R6 K reaches threshold");
    drive(2'b01, 1, 12, "R8 K after resume");
    check_count(n_res, 1, "R8 single resume");

    // rearm and resume again; R7 K interrupted by J
    drive(2'b00, 1, 45, "R5 rearm again");
    drive(2'b01, 1, 5,  "R7 K short");
    drive(2'b00, 1, 1,  "R7 J gap");
    drive(2'b01, 1, 8,  "R6 K full");
    check_count(n_sleep, 3, "R2 sleep total");
    check_count(n_res, 2, "R6 resume total");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule